// File: doc/BRIEF.md
# Bus-Snooping Duplicate-Tag Invalidator

This block keeps a direct-mapped cache coherent with writes that other bus masters, such as DMA engines, make to memory. It watches every system-bus transaction and acts only on writes. Each write address is physical, so it splits the address into a set index and a tag and looks the line up in a private duplicate of the cache's tag store. When the line is resident, the block clears its own copy. It also sends a one-cycle invalidate pulse with the set index to the cache's primary tag array, so both copies stay identical. Neither the data array nor the primary tag port is ever read.

The cache keeps the duplicate store current through a fill port: every line the cache installs is also written here. The block takes one bus write per clock and answers two clock edges after it samples the write. A fill that lands in the same set during a lookup follows a fixed collision rule. If the fill has the same tag as the snooped write, the line ends invalid. If it has a different tag, the newly filled line is kept.

Top module: `snoop_inval_unit`

## Requirements
- R1: A bus transaction is snooped only when `bus_valid` and `bus_write` are both 1 at a rising edge; reads and idle cycles never cause a pulse and never change stored state.
- R2: The set index is address bits [10:5] and the tag is bits [31:11]; bits [4:0] (byte offset) have no effect on the outcome.
- R3: A snooped write whose tag matches a valid entry in its set raises `inv_valid` for exactly one cycle, two rising edges after the write is sampled, with `inv_index` equal to the write's set index.
- R4: A hit clears the duplicate entry, so a later write to the same line gives no pulse.
- R5: A snooped write that misses gives no pulse and leaves the entry unchanged.
- R6: `fill_valid` at a rising edge installs the tag of `fill_addr` as a valid entry in its set, replacing any earlier line there; a snoop sampled at the same edge already sees it.
- R7: One snooped write is accepted every cycle; back-to-back hits give pulses on consecutive cycles in bus order.
- R8: If a fill to the set being looked up, with the same tag as the snooped write, arrives in the lookup cycle, the invalidate wins: a pulse is sent and the line is left invalid.
- R9: If a fill to the set being looked up, with a different tag, arrives in the lookup cycle, no pulse is sent and the new line stays valid.
- R10: A synchronous active-low reset clears every duplicate entry and holds `inv_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Cache installs a line this cycle |
| fill_addr | input | 32 | Physical address of the installed line |
| bus_valid | input | 1 | A bus transaction is present |
| bus_write | input | 1 | The transaction is a write |
| bus_addr | input | 32 | Physical address of the transaction |
| inv_valid | output | 1 | Invalidate pulse to the primary tag array |
| inv_index | output | 6 | Set index to invalidate |

## Verification
The bench builds the block with its default geometry: 32-bit addresses, 32-byte lines and 64 sets. With these values a hand-written address places the tag and index in known bit fields, and the lowest and highest sets are both reachable. One short vector format covers the plain hit, miss and read cases and both collision cases. Each vector drives a snoop in one cycle and a fill in the next, which lines the fill up with the lookup of that snoop.

// File: rtl/snp_pkg.sv
// Shared definitions for the snoop invalidation unit.
// Assumes: classification values are used only inside this block.
package snp_pkg;

    // Default geometry of the cache being shadowed.
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINE_BYTES = 32;
    localparam int unsigned DEF_SETS       = 64;

    // Outcome of one lookup cycle.
    typedef enum logic [1:0] {
        LK_MISS      = 2'd0,   // no resident line, or no snoop
        LK_HIT       = 2'd1,   // resident line invalidated
        LK_RACE_KILL = 2'd2,   // same-tag fill in flight, invalidate wins
        LK_RACE_KEEP = 2'd3    // other-tag fill replaces the line, no pulse
    } lookup_e;

endpackage

// File: rtl/snp_capture.sv
// Snoop capture stage: registers bus writes and splits the physical
// address into tag and set index. Reads and idle cycles are dropped here.
// Assumes: address is physical and line-aligned fields are fixed by params.
module snp_capture #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 5,
    parameter int unsigned INDEX_W = 6,
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               cap_valid,
    output logic [TAG_W-1:0]   cap_tag,
    output logic [INDEX_W-1:0] cap_index
);

    logic unused_offset;
    assign unused_offset = ^bus_addr[OFF_W-1:0];

    // Capture one write per cycle; only the valid flag is reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= bus_valid && bus_write;
        end
    end

    // Hold the address fields of the last sampled transaction.
    always_ff @(posedge clk) begin
        if (bus_valid && bus_write) begin
            cap_tag   <= bus_addr[ADDR_W-1:OFF_W+INDEX_W];
            cap_index <= bus_addr[OFF_W+INDEX_W-1:OFF_W];
        end
    end

endmodule

// File: rtl/snp_dup_tags.sv
// Duplicate tag store: one valid bit and one tag per set, written by the
// cache fill port and cleared by the snoop kill port. Combinational read.
// Assumes: direct-mapped cache; kill has priority over fill in one set.
module snp_dup_tags #(
    parameter int unsigned SETS  = 64,
    parameter int unsigned TAG_W = 21,
    localparam int unsigned INDEX_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               kill_en,
    input  logic [INDEX_W-1:0] kill_idx,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag
);

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        localparam logic [INDEX_W-1:0] MY_IDX = INDEX_W'(g);

        // Valid bit of this set: kill beats fill, reset clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
            end else if (kill_en && kill_idx == MY_IDX) begin
                vld_q[g] <= 1'b0;
            end else if (fill_en && fill_idx == MY_IDX) begin
                vld_q[g] <= 1'b1;
            end
        end

        // Tag of this set follows every fill.
        always_ff @(posedge clk) begin
            if (fill_en && fill_idx == MY_IDX) begin
                tag_q[g] <= fill_tag;
            end
        end
    end

    // Read port for the lookup stage.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end

    // R4: a killed entry reads invalid on the next cycle.
    a_r4_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |=> !vld_q[$past(kill_idx)]);

    // R6: a fill not overridden by a kill leaves a valid entry with its tag.
    a_r6_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(kill_en && kill_idx == fill_idx))
        |=> (vld_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/snp_decide.sv
// Lookup decision: compares the captured snoop against the stored entry and
// any fill landing in the same set this cycle, then issues the kill and the
// registered invalidate pulse for the primary tag array.
// Assumes: fill and lookup share one cycle; fill data is the newest state.
module snp_decide #(
    parameter int unsigned TAG_W   = 21,
    parameter int unsigned INDEX_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_valid,
    input  logic [TAG_W-1:0]   cap_tag,
    input  logic [INDEX_W-1:0] cap_index,
    input  logic               rd_valid,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    output logic               kill_en,
    output logic [INDEX_W-1:0] kill_idx,
    output logic               inv_valid,
    output logic [INDEX_W-1:0] inv_index
);
    import snp_pkg::*;

    lookup_e outcome;
    logic    same_set;

    // Classify this cycle's lookup including a racing fill.
    always_comb begin
        same_set = fill_en && (fill_idx == cap_index);
        outcome  = LK_MISS;
        if (cap_valid) begin
            if (same_set && fill_tag != cap_tag) begin
                outcome = LK_RACE_KEEP;
            end else if (same_set) begin
                outcome = LK_RACE_KILL;
            end else if (rd_valid && rd_tag == cap_tag) begin
                outcome = LK_HIT;
            end
        end
        kill_en  = (outcome == LK_HIT) || (outcome == LK_RACE_KILL);
        kill_idx = cap_index;
    end

    // Register the pulse sent to the primary tag array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_index <= '0;
        end else begin
            inv_valid <= kill_en;
            inv_index <= kill_idx;
        end
    end

    // R9: a different-tag fill racing the lookup suppresses the pulse.
    a_r9_race_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && fill_en && fill_idx == cap_index && fill_tag != cap_tag)
        |=> !inv_valid);

    // R8: a same-tag fill racing the lookup still yields a pulse.
    a_r8_race_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && fill_en && fill_idx == cap_index && fill_tag == cap_tag)
        |=> (inv_valid && inv_index == $past(cap_index)));

endmodule

// File: rtl/snoop_inval_unit.sv
// Snooping invalidation unit: watches bus writes, looks them up in a
// duplicate tag store and invalidates resident lines in both tag copies.
// Assumes: physical addresses on the bus, direct-mapped cache, one fill
// per cycle from the cache, power-of-two line size and set count.
module snoop_inval_unit #(
    parameter int unsigned ADDR_W     = snp_pkg::DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = snp_pkg::DEF_LINE_BYTES,
    parameter int unsigned SETS       = snp_pkg::DEF_SETS,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned INDEX_W   = $clog2(SETS),
    localparam int unsigned TAG_W     = ADDR_W - OFF_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               inv_valid,
    output logic [INDEX_W-1:0] inv_index
);

    localparam int unsigned IDX_HI = OFF_W + INDEX_W - 1;

    logic               cap_valid;
    logic [TAG_W-1:0]   cap_tag;
    logic [INDEX_W-1:0] cap_index;
    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag;
    logic               kill_en;
    logic [INDEX_W-1:0] kill_idx;
    logic [INDEX_W-1:0] fill_idx;
    logic [TAG_W-1:0]   fill_tag;
    logic               unused_fill_off;

    // Split the fill address into set and tag.
    always_comb begin
        fill_idx = fill_addr[IDX_HI:OFF_W];
        fill_tag = fill_addr[ADDR_W-1:IDX_HI+1];
    end
    assign unused_fill_off = ^fill_addr[OFF_W-1:0];

    snp_capture #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .INDEX_W (INDEX_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cap_valid (cap_valid),
        .cap_tag   (cap_tag),
        .cap_index (cap_index)
    );

    snp_dup_tags #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .kill_en  (kill_en),
        .kill_idx (kill_idx),
        .rd_idx   (cap_index),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag)
    );

    snp_decide #(
        .TAG_W   (TAG_W),
        .INDEX_W (INDEX_W)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_tag   (cap_tag),
        .cap_index (cap_index),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .fill_en   (fill_valid),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .kill_en   (kill_en),
        .kill_idx  (kill_idx),
        .inv_valid (inv_valid),
        .inv_index (inv_index)
    );

    // R1: every pulse traces back to a bus write two edges earlier.
    a_r1_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(bus_valid && bus_write, 2));

    // R3: the pulse carries the set index of that write.
    a_r3_pulse_index: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_index == $past(bus_addr[IDX_HI:OFF_W], 2));

endmodule

// File: tb/test_snoop_inval_unit.sv
module test_snoop_inval_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        inv_valid;
    logic [5:0]  inv_index;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    snoop_inval_unit i_snoop_inval_unit (
        .clk (clk), .rst_n (rst_n),
        .fill_valid (fill_valid), .fill_addr (fill_addr),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .inv_valid (inv_valid), .inv_index (inv_index)
    );

    // Address = tag[31:11] | index[10:5] | offset[4:0].
    typedef struct packed {
        logic        fa_v;  logic [31:0] fa;    // fill in snoop cycle
        logic        sv;    logic        sw;  logic [31:0] sa;  // bus
        logic        fb_v;  logic [31:0] fb;    // fill in lookup cycle
        logic        ev;    logic [5:0]  ei;    // expected pulse
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_9060, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 6'd0,  4'd6}, // R6 fill tag 0x12 set 3
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_9064, 1'b0, 32'h0,         1'b1, 6'd3,  4'd3}, // R3 R2 hit, offset 4
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_907F, 1'b0, 32'h0,         1'b0, 6'd0,  4'd4}, // R4 line cleared
        '{1'b1, 32'h0000_9060, 1'b1, 1'b0, 32'h0000_9060, 1'b0, 32'h0,         1'b0, 6'd0,  4'd1}, // R1 read ignored
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_9860, 1'b0, 32'h0,         1'b0, 6'd0,  4'd5}, // R5 other tag misses
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_9060, 1'b0, 32'h0,         1'b1, 6'd3,  4'd5}, // R5 R1 line kept
        '{1'b1, 32'hFFFF_FFE0, 1'b1, 1'b1, 32'hFFFF_FFE0, 1'b0, 32'h0,         1'b1, 6'd63, 4'd6}, // R6 same-edge fill, top set
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h1000_0040, 1'b1, 32'h1000_0040, 1'b1, 6'd2,  4'd8}, // R8 race same tag
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h1000_0040, 1'b0, 32'h0,         1'b0, 6'd0,  4'd8}, // R8 left invalid
        '{1'b1, 32'h1000_0040, 1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 6'd0,  4'd6}, // R6 refill
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h1000_0040, 1'b1, 32'h1000_0840, 1'b0, 6'd0,  4'd9}, // R9 race other tag
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h1000_0840, 1'b0, 32'h0,         1'b1, 6'd2,  4'd9}, // R9 new line valid
        '{1'b0, 32'h0,         1'b0, 1'b1, 32'h1000_0840, 1'b0, 32'h0,         1'b0, 6'd0,  4'd1}  // R1 no valid
    };

    task automatic check(input string tag, input logic ev, input logic [5:0] ei);
        checks++;
        if (inv_valid !== ev || (ev && inv_index !== ei)) begin
            errors++;
            $display("FAIL %s: inv_valid=%0b inv_index=%0d expected %0b/%0d",
                     tag, inv_valid, inv_index, ev, ei);
        end
    endtask

    task automatic idle();
        fill_valid = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        check("R10 reset output", 1'b0, 6'd0);
        rst_n = 1'b1;
        step();

        // Table: snoop cycle, lookup cycle, then sample the pulse.
        for (int v = 0; v < NV; v++) begin
            fill_valid = VEC[v].fa_v; fill_addr = VEC[v].fa;
            bus_valid = VEC[v].sv; bus_write = VEC[v].sw; bus_addr = VEC[v].sa;
            step();
            idle();
            fill_valid = VEC[v].fb_v; fill_addr = VEC[v].fb;
            check($sformatf("R%0d vec %0d no early pulse", VEC[v].req, v), 1'b0, 6'd0);
            step();
            idle();
            check($sformatf("R%0d vec %0d", VEC[v].req, v), VEC[v].ev, VEC[v].ei);
            step();
            check($sformatf("R3 vec %0d single pulse", v), 1'b0, 6'd0);
        end

        // R7: back-to-back hits on sets 5 and 6.
        fill_valid = 1'b1; fill_addr = 32'h0000_00A0; step();
        fill_addr = 32'h0000_00C0; step();
        idle();
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h0000_00A0; step();
        bus_addr = 32'h0000_00C0; step();
        idle();
        check("R7 first pulse", 1'b1, 6'd5);
        step();
        check("R7 second pulse", 1'b1, 6'd6);
        step();
        check("R7 pulses end", 1'b0, 6'd0);

        // R10: reset clears stored entries.
        fill_valid = 1'b1; fill_addr = 32'h0000_0100; step();
        idle();
        rst_n = 1'b0; step();
        rst_n = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h0000_0100; step();
        idle(); step();
        check("R10 entry cleared by reset", 1'b0, 6'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule